// File: doc/BRIEF.md
# Prescaled Match Timer with PWM

A free-running up-counter that advances once every `PRESC + 1` clock cycles while its run bit is set. A bank of match channels compares the counter against programmable values. When a channel's value is reached, that channel can do any mix of three things:

- restart the counter from zero;
- freeze the counter and drop the run bit;
- raise a status flag that can drive a shared interrupt line.

Every channel also owns an output pin. In normal use the pin follows a small per-channel action: keep, drive low, drive high or toggle. Any channel except the last can instead be switched to pulse-width mode. The last channel is reserved as the period source: when its restart action is enabled, the counter cycles through `0..MATCH[last]`. A pulse-width pin is low while the counter is below its channel's match value and high from that value until the period ends. A match value above the period therefore gives a constant low.

Software reaches everything through a single-cycle register bus. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The register addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | control, run bit at bit 0 | read/write |
| 1 | counter | read/write |
| 2 | prescale limit | read/write |
| 3 | prescale phase | read only |
| 4 | per-channel action groups | read/write |
| 5 | pin configuration | read/write |
| 6 | pulse-width enables | read/write |
| 7 | status flags | write-one-to-clear |
| 8+n | match value of channel n | read/write |

Top module: `tmr_match_pwm`

## Requirements
- R1: After synchronous reset every readable register, every pin of `match_out` and `irq` are 0.
- R2: While the run bit (address 0, bit 0) is 1, the counter (address 1) rises by one every PRESC+1 clock cycles, where PRESC is the value at address 2; PRESC = 0 counts on every clock.
- R3: Writing 0 to the run bit freezes the counter at its present value.
- R4: Channel n owns the 3-bit group at bits 3n+2..3n of address 4. The lowest bit of the group (restart) makes a match reload the counter with 0 instead of advancing it. With restart set on the last channel, the counter cycles through 0..MATCH[last], so one period spans MATCH[last]+1 counts.
- R5: The middle bit of the group (freeze) makes a match keep the counter at the match value and clear the run bit. When restart and freeze are both set, the counter becomes 0 and the run bit is cleared.
- R6: A match on channel n sets flag bit n at address 7. Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some flag n is set whose interrupt-enable bit (bit 3n+2 of address 4) is 1.
- R8: Address 5 holds the pin states at bits NCH-1..0, which software may preset, and a 2-bit action per channel at bits NCH+2n+1..NCH+2n. On a match the action is applied to the pin: 0 keep, 1 low, 2 high, 3 toggle.
- R9: Bit n of address 6 puts channel n in pulse-width mode. The bit for the last channel is ignored and always reads 0. In pulse-width mode the pin is low while counter < MATCH[n] and high otherwise.
- R10: In pulse-width mode, a MATCH[n] larger than MATCH[last] keeps the pin permanently low, and MATCH[n] = 0 keeps it permanently high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_we | input | 1 | write strobe |
| bus_addr | input | AW | register address |
| bus_wdata | input | W | write data |
| bus_rdata | output | W | read data for bus_addr |
| match_out | output | NCH | per-channel output pins |
| irq | output | 1 | interrupt request |

## Verification
The period assertion assumes two things about the inputs: the period channel's match value and its restart bit stay steady, and the counter is not rewritten to a value beyond the period. The stimulus respects this by stopping the timer and clearing the counter before it reprograms any of these. The prescale-phase assertion assumes that the limit is only rewritten as a whole-register write. It exempts the single cycle after such a write. The pulse-width vectors are each measured over exactly one full period, so the high-cycle count does not depend on the phase at which the measurement starts.

// File: rtl/timer_pkg.sv
package timer_pkg;

    // register addresses
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_COUNT  = 1;
    localparam int ADDR_PRESC  = 2;
    localparam int ADDR_PHASE  = 3;
    localparam int ADDR_ACTION = 4;
    localparam int ADDR_PINCFG = 5;
    localparam int ADDR_PWMEN  = 6;
    localparam int ADDR_FLAGS  = 7;
    localparam int ADDR_MATCH0 = 8;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'd0,
        PIN_LOW  = 2'd1,
        PIN_HIGH = 2'd2,
        PIN_FLIP = 2'd3
    } pin_act_e;

    // one action group, restart in the least significant bit
    typedef struct packed {
        logic irq_en;
        logic freeze;
        logic restart;
    } chan_ctl_t;

    function automatic logic apply_pin(input logic cur, input pin_act_e act);
        case (act)
            PIN_LOW:  return 1'b0;
            PIN_HIGH: return 1'b1;
            PIN_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] phase,
    output logic         tick
);
    assign tick = run && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (!run) phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
    import timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic [W-1:0] match_val,
    input  logic         pwm_en,
    input  logic [1:0]   act,
    input  logic         preset_we,
    input  logic         preset_val,
    output logic         hit,
    output logic         state,
    output logic         pin
);
    assign hit = tick && (count == match_val);

    always_ff @(posedge clk) begin
        if (rst)            state <= 1'b0;
        else if (preset_we) state <= preset_val;
        else if (hit)       state <= apply_pin(state, pin_act_e'(act));
    end

    assign pin = pwm_en ? (count >= match_val) : state;
endmodule

// File: rtl/tmr_match_pwm.sv
module tmr_match_pwm
    import timer_pkg::*;
#(
    parameter int W   = 32,
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic [NCH-1:0] match_out,
    output logic          irq
);
    localparam int PER = NCH - 1;
    localparam int AGW = 3 * NCH;
    localparam int PCW = NCH + 2 * NCH;
    localparam logic [NCH-1:0] PWM_MASK = NCH'((1 << PER) - 1);

    logic            run;
    logic [W-1:0]    count;
    logic [W-1:0]    presc;
    logic [W-1:0]    phase;
    logic            tick;
    logic [AGW-1:0]  act_r;
    logic [2*NCH-1:0] pact_r;
    logic [NCH-1:0]  pwm_en_r;
    logic [NCH-1:0]  flags;
    logic [NCH-1:0]  ev;
    logic [NCH-1:0]  st;
    logic [NCH-1:0]  rst_bits;
    logic [NCH-1:0]  stop_bits;
    logic [NCH-1:0]  ien_bits;
    logic [NCH-1:0]  wr_match;
    logic [W-1:0]    mval [NCH];
    logic            restart_hit;
    logic            stop_hit;

    logic wr_ctrl, wr_count, wr_presc, wr_action, wr_pincfg, wr_pwmen, wr_flags;
    assign wr_ctrl   = bus_we && (bus_addr == AW'(ADDR_CTRL));
    assign wr_count  = bus_we && (bus_addr == AW'(ADDR_COUNT));
    assign wr_presc  = bus_we && (bus_addr == AW'(ADDR_PRESC));
    assign wr_action = bus_we && (bus_addr == AW'(ADDR_ACTION));
    assign wr_pincfg = bus_we && (bus_addr == AW'(ADDR_PINCFG));
    assign wr_pwmen  = bus_we && (bus_addr == AW'(ADDR_PWMEN));
    assign wr_flags  = bus_we && (bus_addr == AW'(ADDR_FLAGS));

    tmr_prescaler #(.W(W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .limit(presc),
        .phase(phase),
        .tick (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chan_ctl_t ctl;
        assign ctl          = chan_ctl_t'(act_r[3*g +: 3]);
        assign rst_bits[g]  = ctl.restart;
        assign stop_bits[g] = ctl.freeze;
        assign ien_bits[g]  = ctl.irq_en;
        assign wr_match[g]  = bus_we && (bus_addr == AW'(ADDR_MATCH0 + g));

        always_ff @(posedge clk) begin
            if (rst)              mval[g] <= '0;
            else if (wr_match[g]) mval[g] <= bus_wdata;
        end

        tmr_match_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .count     (count),
            .match_val (mval[g]),
            .pwm_en    (pwm_en_r[g]),
            .act       (pact_r[2*g +: 2]),
            .preset_we (wr_pincfg),
            .preset_val(bus_wdata[g]),
            .hit       (ev[g]),
            .state     (st[g]),
            .pin       (match_out[g])
        );
    end

    assign restart_hit = |(ev & rst_bits);
    assign stop_hit    = |(ev & stop_bits);

    // counter and run control
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run   <= 1'b0;
        end else begin
            if (wr_count)         count <= bus_wdata;
            else if (tick) begin
                if (restart_hit)   count <= '0;
                else if (!stop_hit) count <= count + 1'b1;
            end
            if (wr_ctrl)          run <= bus_wdata[0];
            else if (stop_hit)    run <= 1'b0;
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            presc    <= '0;
            act_r    <= '0;
            pact_r   <= '0;
            pwm_en_r <= '0;
        end else begin
            if (wr_presc)  presc    <= bus_wdata;
            if (wr_action) act_r    <= bus_wdata[AGW-1:0];
            if (wr_pincfg) pact_r   <= bus_wdata[PCW-1:NCH];
            if (wr_pwmen)  pwm_en_r <= bus_wdata[NCH-1:0] & PWM_MASK;
        end
    end

    // status flags: a new match wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~(wr_flags ? bus_wdata[NCH-1:0] : '0)) | ev;
    end

    assign irq = |(flags & ien_bits);

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADDR_CTRL:   bus_rdata = W'(run);
            ADDR_COUNT:  bus_rdata = count;
            ADDR_PRESC:  bus_rdata = presc;
            ADDR_PHASE:  bus_rdata = phase;
            ADDR_ACTION: bus_rdata = W'(act_r);
            ADDR_PINCFG: bus_rdata = W'({pact_r, st});
            ADDR_PWMEN:  bus_rdata = W'(pwm_en_r);
            ADDR_FLAGS:  bus_rdata = W'(flags);
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (int'(bus_addr) == ADDR_MATCH0 + i) bus_rdata = mval[i];
            end
        endcase
    end
endmodule

// File: rtl/tmr_match_pwm_chk.sv
module tmr_match_pwm_chk #(
    parameter int W   = 32,
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           run,
    input logic [W-1:0]   count,
    input logic [W-1:0]   presc,
    input logic [W-1:0]   phase,
    input logic [W-1:0]   per_val,
    input logic           per_restart,
    input logic           stop_hit,
    input logic           wr_ctrl,
    input logic           wr_count,
    input logic           wr_presc,
    input logic [NCH-1:0] ev,
    input logic [NCH-1:0] flags,
    input logic           irq
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_count) && count != $past(count)) |-> $past(tick));

    // R2
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_presc) |-> phase <= presc);

    // R4
    period_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (per_restart && $past(per_restart) && $stable(per_val) && !$past(wr_count)
         && $past(count) <= $past(per_val)) |-> count <= per_val);

    // R5
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(stop_hit) && !$past(wr_ctrl)) |-> !run);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));
endmodule

bind tmr_match_pwm tmr_match_pwm_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run),
    .count      (count),
    .presc      (presc),
    .phase      (phase),
    .per_val    (mval[NCH-1]),
    .per_restart(rst_bits[NCH-1]),
    .stop_hit   (stop_hit),
    .wr_ctrl    (wr_ctrl),
    .wr_count   (wr_count),
    .wr_presc   (wr_presc),
    .ev         (ev),
    .flags      (flags),
    .irq        (irq)
);

// File: tb/tb_tmr_match_pwm.sv
`timescale 1ns/1ps
module tb_tmr_match_pwm;
    localparam int W = 32, NCH = 4, AW = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           bus_we;
    logic [AW-1:0]  bus_addr;
    logic [W-1:0]   bus_wdata;
    logic [W-1:0]   bus_rdata;
    logic [NCH-1:0] match_out;
    logic           irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_match_pwm #(.W(W), .NCH(NCH), .AW(AW)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .match_out(match_out), .irq(irq)
    );

    // pulse-width vectors: prescale, period match, channel-0 match, expected high cycles
    localparam int NV = 6;
    localparam int unsigned VEC [NV][4] = '{
        '{0,  9, 3,  7},
        '{1,  4, 2,  6},
        '{2,  5, 0, 18},
        '{0,  7, 8,  0},
        '{3,  3, 3,  4},
        '{0, 15, 15, 1}
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        wr(0, 0); wr(1, 0); wr(4, 0); wr(6, 0); wr(5, 0); wr(7, 32'hF); wr(2, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        int hi;
        int mx;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            check($sformatf("R1 reg %0d", a), v, 0);
        end
        check("R1 match_out", W'(match_out), 0);
        check("R1 irq", W'(irq), 0);

        // R9 R10: pulse-width vectors over one full period
        for (int i = 0; i < NV; i++) begin
            clean();
            wr(2, VEC[i][0]);
            wr(8 + 3, VEC[i][1]);
            wr(8, VEC[i][2]);
            wr(4, 32'h200);          // restart on period channel
            wr(6, 32'h1);
            wr(0, 1);
            hi = 0;
            for (int k = 0; k < int'((VEC[i][0] + 1) * (VEC[i][1] + 1)); k++) begin
                #1;
                if (match_out[0]) hi++;
                @(negedge clk);
            end
            check($sformatf("R9 R10 vector %0d high cycles", i), W'(hi), W'(VEC[i][3]));
        end

        // R9: enable bit of the period channel is ignored
        clean();
        wr(6, 32'hF);
        rd(6, v);
        check("R9 pwm enable readback", v, 32'h7);
        wr(6, 0);

        // R2: prescale 3, eight cycles give two counts
        clean();
        wr(2, 3);
        wr(0, 1);
        idle(8);
        rd(1, v);
        check("R2 count after prescaled run", v, 2);
        // R3: run cleared freezes counter
        wr(0, 0);
        rd(1, v);
        check("R3 count at stop", v, 2);
        idle(10);
        rd(1, v);
        check("R3 count held", v, 2);

        // R4: period restart keeps count within 0..4
        clean();
        wr(8 + 3, 4);
        wr(4, 32'h200);
        wr(0, 1);
        mx = 0;
        for (int k = 0; k < 15; k++) begin
            rd(1, v);
            if (int'(v) > mx) mx = int'(v);
            @(negedge clk);
        end
        check("R4 max count within period", W'(mx), 4);

        // R5: freeze on channel 1 at 5
        clean();
        wr(8 + 3, 32'hFFFF_FFFF);
        wr(8 + 1, 5);
        wr(4, 32'h10);
        wr(0, 1);
        idle(20);
        rd(1, v);
        check("R5 frozen count", v, 5);
        rd(0, v);
        check("R5 run cleared", v, 0);
        // R6 R7: flag set, irq masked
        rd(7, v);
        check("R6 flag bit1 set", v & 32'h2, 32'h2);
        check("R7 irq masked", W'(irq), 0);
        wr(4, 32'h20);
        check("R7 irq enabled", W'(irq), 1);
        wr(7, 32'h0);
        rd(7, v);
        check("R6 write zero keeps flag", v & 32'h2, 32'h2);
        wr(7, 32'hF);
        rd(7, v);
        check("R6 write one clears", v, 0);
        check("R7 irq after clear", W'(irq), 0);

        // R5: restart plus freeze
        clean();
        wr(8 + 3, 32'hFFFF_FFFF);
        wr(8 + 1, 5);
        wr(4, 32'h18);
        wr(0, 1);
        idle(20);
        rd(1, v);
        check("R5 restart and freeze count", v, 0);
        rd(0, v);
        check("R5 restart and freeze run", v, 0);

        // R8: pin actions, ch0 high, ch1 low, ch2 toggle with freeze
        clean();
        wr(8 + 0, 2);
        wr(8 + 1, 1);
        wr(8 + 2, 3);
        wr(8 + 3, 9);
        wr(4, 32'h280);
        wr(5, 32'h366);
        rd(5, v);
        check("R8 preset readback", v, 32'h366);
        wr(0, 1);
        idle(20);
        check("R8 pins after actions", W'(match_out), 32'h1);
        rd(5, v);
        check("R8 pin state readback", v, 32'h361);
        rd(1, v);
        check("R5 freeze on channel 2", v, 3);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule